// File: doc/BRIEF.md
# Interrupt Event Status and Enable Bank

This block keeps a pending flag and an enable flag for each of 64 interrupt events and exposes them through a 32-bit register port. Events arrive as raw lines. Each line has its own polarity setting and its own type setting. A pulse-type line latches pending on its transition into the active state. A level-type line latches pending on every cycle that it is active.

Software changes per-event state in one of two ways. It can write an event number to an index register, which touches exactly one event. It can also write a bitmask to a pair of words: the low word covers events 0 to 31 and the high word covers events 32 to 63. In a bitmask, only the bits written as 1 act.

The block drives a 64-bit vector of events that are both pending and enabled. A single global enable gates that vector. Routing events to channels and hosts, and choosing priority among them, happen downstream of this block.

Top module: `evt_bank`

## Requirements
- R1: After reset, every pending flag, every enable flag and the global enable are 0. Every polarity bit is 1 and every type bit is 0. `irq_o` is 0.
- R2: A write of event number N to 0x04 sets pending[N]. A write of N to 0x08 clears pending[N]. The change is visible from the next clock.
- R3: A write of N to 0x0C sets enable[N]. A write of N to 0x10 clears enable[N].
- R4: An index write (to 0x04, 0x08, 0x0C or 0x10) whose 32-bit value is 64 or more changes no state. This holds even when its low six bits name a valid event.
- R5: A write to the enable-set mask at 0x30 (events 0-31) or 0x34 (events 32-63) sets enable for each bit written 1. The same write to 0x38 or 0x3C clears enable for each bit written 1. Bits written 0 leave their flag unchanged.
- R6: A write to the pending-clear mask at 0x28 (events 0-31) or 0x2C (events 32-63) clears pending for each bit written 1. Bits written 0 have no effect.
- R7: Polarity words sit at 0x40 and 0x44, where bit 1 means active high and bit 0 means active low. Type words sit at 0x48 and 0x4C, where bit 0 means pulse and bit 1 means level. A pulse event sets pending only in the cycle after its line goes from inactive to active. Holding the line active does not set pending again.
- R8: A level event sets pending on every clock while its line is active, so a software clear does not hold while the line stays active.
- R9: When a line-driven set and a software clear of the same event occur on the same clock, the event ends up pending.
- R10: `irq_o[N]` equals pending[N] AND enable[N] when bit 0 of the global enable at 0x00 is 1. Otherwise `irq_o` is all zero.
- R11: Reads return the following: the global enable at 0x00 in bit 0; pending at 0x20 and 0x24; enable at 0x50 and 0x54; polarity at 0x40 and 0x44; type at 0x48 and 0x4C. Any other address reads 0, write-only addresses included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 64 | Raw event lines, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 64 | Pending and enabled events, gated by global enable |

## Verification
The bench builds the block with its default parameters: 64 events on a 32-bit data path. With these values both mask words and both halves of every readback pair are in play. This lets the bench catch a word-select or offset slip on the high half, events 32 to 63. Because the data path is 32 bits wide, the bench can write index values above 63 whose low six bits still name a real event. An index decoder that truncates its input would then act on that event, and the bench would see it.

// File: rtl/evt_bank_pkg.sv
package evt_bank_pkg;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] A_GLB      = 8'h00;
  localparam logic [REG_AW-1:0] A_PSET_IDX = 8'h04;
  localparam logic [REG_AW-1:0] A_PCLR_IDX = 8'h08;
  localparam logic [REG_AW-1:0] A_ESET_IDX = 8'h0C;
  localparam logic [REG_AW-1:0] A_ECLR_IDX = 8'h10;
  localparam logic [REG_AW-1:0] A_RAW      = 8'h20;
  localparam logic [REG_AW-1:0] A_PCLR_MSK = 8'h28;
  localparam logic [REG_AW-1:0] A_ESET_MSK = 8'h30;
  localparam logic [REG_AW-1:0] A_ECLR_MSK = 8'h38;
  localparam logic [REG_AW-1:0] A_POL      = 8'h40;
  localparam logic [REG_AW-1:0] A_TYP      = 8'h48;
  localparam logic [REG_AW-1:0] A_EN       = 8'h50;

  // word w of a two-word group sits at base + 4*w
  function automatic logic [REG_AW-1:0] word_addr(logic [REG_AW-1:0] base, int w);
    return base + REG_AW'(4 * w);
  endfunction
endpackage

// File: rtl/evt_wr_decode.sv
module evt_wr_decode
  import evt_bank_pkg::*;
#(
  parameter int unsigned NUM_EVT = 64,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned NUM_WORDS = NUM_EVT / DATA_W,
  localparam int unsigned IDX_W     = $clog2(NUM_EVT)
) (
  input  logic                 wr_en_i,
  input  logic [REG_AW-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [NUM_EVT-1:0]   pend_set_o,
  output logic [NUM_EVT-1:0]   pend_clr_o,
  output logic [NUM_EVT-1:0]   en_set_o,
  output logic [NUM_EVT-1:0]   en_clr_o,
  output logic                 glb_we_o,
  output logic [NUM_WORDS-1:0] pol_we_o,
  output logic [NUM_WORDS-1:0] typ_we_o
);
  logic             idx_ok;
  logic [IDX_W-1:0] idx;

  // full-width range check: no aliasing of out-of-range indices
  assign idx_ok = wr_data_i < DATA_W'(NUM_EVT);
  assign idx    = wr_data_i[IDX_W-1:0];

  always_comb begin
    pend_set_o = '0;
    pend_clr_o = '0;
    en_set_o   = '0;
    en_clr_o   = '0;
    glb_we_o   = 1'b0;
    pol_we_o   = '0;
    typ_we_o   = '0;
    if (wr_en_i) begin
      glb_we_o = (wr_addr_i == A_GLB);
      if (idx_ok) begin
        if (wr_addr_i == A_PSET_IDX) pend_set_o[idx] = 1'b1;
        if (wr_addr_i == A_PCLR_IDX) pend_clr_o[idx] = 1'b1;
        if (wr_addr_i == A_ESET_IDX) en_set_o[idx]   = 1'b1;
        if (wr_addr_i == A_ECLR_IDX) en_clr_o[idx]   = 1'b1;
      end
      for (int w = 0; w < int'(NUM_WORDS); w++) begin
        if (wr_addr_i == word_addr(A_PCLR_MSK, w)) pend_clr_o[w*DATA_W +: DATA_W] |= wr_data_i;
        if (wr_addr_i == word_addr(A_ESET_MSK, w)) en_set_o[w*DATA_W +: DATA_W]   |= wr_data_i;
        if (wr_addr_i == word_addr(A_ECLR_MSK, w)) en_clr_o[w*DATA_W +: DATA_W]   |= wr_data_i;
        pol_we_o[w] = (wr_addr_i == word_addr(A_POL, w));
        typ_we_o[w] = (wr_addr_i == word_addr(A_TYP, w));
      end
    end
  end
endmodule

// File: rtl/evt_detect.sv
module evt_detect #(
  parameter int unsigned NUM_EVT = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] pol_i,
  input  logic [NUM_EVT-1:0] typ_i,
  output logic [NUM_EVT-1:0] hw_set_o
);
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic act;
    logic act_q;
    assign act = pol_i[g] ? evt_i[g] : ~evt_i[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_q <= 1'b0;
      else         act_q <= act;
    end
    // type 1: level, type 0: rising edge of the active sense
    assign hw_set_o[g] = typ_i[g] ? act : (act & ~act_q);
  end
endmodule

// File: rtl/evt_state.sv
module evt_state #(
  parameter int unsigned NUM_EVT = 64,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned NUM_WORDS = NUM_EVT / DATA_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_EVT-1:0]   hw_set_i,
  input  logic [NUM_EVT-1:0]   pend_set_i,
  input  logic [NUM_EVT-1:0]   pend_clr_i,
  input  logic [NUM_EVT-1:0]   en_set_i,
  input  logic [NUM_EVT-1:0]   en_clr_i,
  input  logic                 glb_we_i,
  input  logic [NUM_WORDS-1:0] pol_we_i,
  input  logic [NUM_WORDS-1:0] typ_we_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [NUM_EVT-1:0]   pend_o,
  output logic [NUM_EVT-1:0]   en_o,
  output logic [NUM_EVT-1:0]   pol_o,
  output logic [NUM_EVT-1:0]   typ_o,
  output logic                 glb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      en_o   <= '0;
      glb_o  <= 1'b0;
      pol_o  <= '1;
      typ_o  <= '0;
    end else begin
      // set terms after clear: a line-driven set is never lost
      pend_o <= (pend_o & ~pend_clr_i) | pend_set_i | hw_set_i;
      en_o   <= (en_o & ~en_clr_i) | en_set_i;
      if (glb_we_i) glb_o <= wr_data_i[0];
      for (int w = 0; w < int'(NUM_WORDS); w++) begin
        if (pol_we_i[w]) pol_o[w*DATA_W +: DATA_W] <= wr_data_i;
        if (typ_we_i[w]) typ_o[w*DATA_W +: DATA_W] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/evt_bank.sv
module evt_bank
  import evt_bank_pkg::*;
#(
  parameter int unsigned NUM_EVT = 64,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned NUM_WORDS = NUM_EVT / DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [REG_AW-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [REG_AW-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [NUM_EVT-1:0] irq_o
);
  logic [NUM_EVT-1:0]   pend_set, pend_clr, en_set, en_clr, hw_set;
  logic [NUM_EVT-1:0]   pend_q, en_q, pol_q, typ_q;
  logic                 glb_we, glb_q;
  logic [NUM_WORDS-1:0] pol_we, typ_we;

  evt_wr_decode #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) i_dec (
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .pend_set_o (pend_set),
    .pend_clr_o (pend_clr),
    .en_set_o   (en_set),
    .en_clr_o   (en_clr),
    .glb_we_o   (glb_we),
    .pol_we_o   (pol_we),
    .typ_we_o   (typ_we)
  );

  evt_detect #(.NUM_EVT(NUM_EVT)) i_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .pol_i    (pol_q),
    .typ_i    (typ_q),
    .hw_set_o (hw_set)
  );

  evt_state #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) i_st (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_set_i   (hw_set),
    .pend_set_i (pend_set),
    .pend_clr_i (pend_clr),
    .en_set_i   (en_set),
    .en_clr_i   (en_clr),
    .glb_we_i   (glb_we),
    .pol_we_i   (pol_we),
    .typ_we_i   (typ_we),
    .wr_data_i  (wr_data_i),
    .pend_o     (pend_q),
    .en_o       (en_q),
    .pol_o      (pol_q),
    .typ_o      (typ_q),
    .glb_o      (glb_q)
  );

  assign irq_o = glb_q ? (pend_q & en_q) : '0;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_GLB) rd_data_o[0] = glb_q;
    for (int w = 0; w < int'(NUM_WORDS); w++) begin
      if (rd_addr_i == word_addr(A_RAW, w)) rd_data_o = pend_q[w*DATA_W +: DATA_W];
      if (rd_addr_i == word_addr(A_EN, w))  rd_data_o = en_q[w*DATA_W +: DATA_W];
      if (rd_addr_i == word_addr(A_POL, w)) rd_data_o = pol_q[w*DATA_W +: DATA_W];
      if (rd_addr_i == word_addr(A_TYP, w)) rd_data_o = typ_q[w*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/evt_bank_chk.sv
module evt_bank_chk
  import evt_bank_pkg::*;
#(
  parameter int unsigned NUM_EVT = 64,
  parameter int unsigned DATA_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               wr_en_i,
  input logic [REG_AW-1:0]  wr_addr_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [NUM_EVT-1:0] irq_o,
  input logic [NUM_EVT-1:0] pend_q,
  input logic [NUM_EVT-1:0] en_q,
  input logic [NUM_EVT-1:0] pol_q,
  input logic [NUM_EVT-1:0] typ_q
);
  logic [NUM_EVT-1:0] lvl_act;
  assign lvl_act = typ_q & ~(evt_i ^ pol_q);

  assert_glb_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_GLB && !wr_data_i[0]) |=> (irq_o == '0));

  assert_idx_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == A_ESET_IDX || wr_addr_i == A_ECLR_IDX)
     && wr_data_i >= DATA_W'(NUM_EVT)) |=> $stable(en_q));

  assert_mask_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_ECLR_MSK) |=> ((en_q[DATA_W-1:0] & $past(wr_data_i)) == '0));

  // R8 and R9: an active level line is pending next cycle whatever software wrote
  assert_level_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(lvl_act)) == $past(lvl_act)));

  assert_reset_irq_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (irq_o == '0));
endmodule

bind evt_bank evt_bank_chk #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .irq_o     (irq_o),
  .pend_q    (pend_q),
  .en_q      (en_q),
  .pol_q     (pol_q),
  .typ_q     (typ_q)
);

// File: tb/test_evt_bank.sv
`timescale 1ns/1ps
module test_evt_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [7:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [63:0] irq_o;

  evt_bank i_evt_bank (.*);

  always #4 clk_i = ~clk_i;

  int    checks = 0, fails = 0;
  bit    done = 0;
  string cur_tag = "R1";

  // behavioural reference state
  logic [63:0] m_pend, m_en, m_pol, m_typ, m_actp;
  logic        m_glb;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pend = '0; m_en = '0; m_pol = '1; m_typ = '0; m_actp = '0; m_glb = 0;
    end else begin
      for (int i = 0; i < 64; i++) begin
        int  wd, bt;
        bit  act, hw, pset, pclr, eset, eclr;
        wd   = i / 32; bt = i % 32;
        act  = m_pol[i] ? evt_i[i] : !evt_i[i];
        hw   = m_typ[i] ? act : (act && !m_actp[i]);
        m_actp[i] = act;
        pset = wr_en_i && wr_addr_i == 8'h04 && wr_data_i == i;
        pclr = wr_en_i && ((wr_addr_i == 8'h08 && wr_data_i == i) ||
                           (wr_addr_i == 8'h28 + 4*wd && wr_data_i[bt]));
        eset = wr_en_i && ((wr_addr_i == 8'h0C && wr_data_i == i) ||
                           (wr_addr_i == 8'h30 + 4*wd && wr_data_i[bt]));
        eclr = wr_en_i && ((wr_addr_i == 8'h10 && wr_data_i == i) ||
                           (wr_addr_i == 8'h38 + 4*wd && wr_data_i[bt]));
        m_pend[i] = (m_pend[i] && !pclr) || pset || hw;
        m_en[i]   = (m_en[i] && !eclr) || eset;
        if (wr_en_i && wr_addr_i == 8'h40 + 4*wd) m_pol[i] = wr_data_i[bt];
        if (wr_en_i && wr_addr_i == 8'h48 + 4*wd) m_typ[i] = wr_data_i[bt];
      end
      if (wr_en_i && wr_addr_i == 8'h00) m_glb = wr_data_i[0];
    end
  end

  function automatic logic [31:0] m_rd(logic [7:0] a);
    logic [31:0] r = '0;
    if (a == 8'h00) r[0] = m_glb;
    for (int w = 0; w < 2; w++) begin
      if (a == 8'h20 + 4*w) r = m_pend[w*32 +: 32];
      if (a == 8'h50 + 4*w) r = m_en[w*32 +: 32];
      if (a == 8'h40 + 4*w) r = m_pol[w*32 +: 32];
      if (a == 8'h48 + 4*w) r = m_typ[w*32 +: 32];
    end
    return r;
  endfunction

  task automatic check(string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", cur_tag, what, got, exp);
    end
  endtask

  // per-clock comparison of the output vector
  always @(negedge clk_i) begin
    if (rst_ni && !done) check("irq_o", irq_o, m_glb ? (m_pend & m_en) : 64'h0);
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      wr_en_i = 0;
    end
  endtask

  task automatic rd_chk(logic [7:0] a);
    @(negedge clk_i);
    wr_en_i = 0; rd_addr_i = a;
    #1 check($sformatf("read %h", a), {32'h0, rd_data_o}, {32'h0, m_rd(a)});
  endtask

  task automatic set_evt(int i, bit v);
    @(negedge clk_i);
    wr_en_i = 0; evt_i[i] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset values
    cur_tag = "R1";
    rd_chk(8'h00); rd_chk(8'h20); rd_chk(8'h24); rd_chk(8'h50); rd_chk(8'h54);
    rd_chk(8'h40); rd_chk(8'h44); rd_chk(8'h48); rd_chk(8'h4C);
    check("irq_o reset", irq_o, 64'h0);

    wr(8'h00, 32'h1);
    cur_tag = "R2";
    wr(8'h04, 5); wr(8'h04, 40); idle(1);
    rd_chk(8'h20); rd_chk(8'h24);
    wr(8'h08, 5); idle(1); rd_chk(8'h20);

    cur_tag = "R3";
    wr(8'h0C, 40); wr(8'h0C, 63); idle(2); rd_chk(8'h54);
    wr(8'h10, 63); idle(1); rd_chk(8'h54);

    cur_tag = "R4";
    wr(8'h04, 64); wr(8'h0C, 100); wr(8'h08, 32'hFFFF_FFE8); wr(8'h0C, 32'h0000_0043);
    wr(8'h10, 32'h0000_0068); idle(1);
    rd_chk(8'h20); rd_chk(8'h24); rd_chk(8'h50); rd_chk(8'h54);

    cur_tag = "R5";
    wr(8'h30, 32'hF0F0_0001); wr(8'h34, 32'h8000_0001); idle(1);
    rd_chk(8'h50); rd_chk(8'h54);
    wr(8'h38, 32'h00F0_0001); wr(8'h3C, 32'h0000_0000); idle(1);
    rd_chk(8'h50); rd_chk(8'h54);

    cur_tag = "R6";
    wr(8'h04, 33); wr(8'h04, 34); wr(8'h04, 1); idle(1);
    wr(8'h2C, 32'h0000_0004); wr(8'h28, 32'h0); idle(1);
    rd_chk(8'h20); rd_chk(8'h24);

    cur_tag = "R7";
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF);
    set_evt(10, 1); idle(3); wr(8'h08, 10); idle(3); rd_chk(8'h20);
    wr(8'h40, 32'hFFFF_EFFF); idle(2); rd_chk(8'h20); rd_chk(8'h40);
    wr(8'h08, 12); idle(2); rd_chk(8'h20);

    cur_tag = "R8";
    wr(8'h48, 32'h0010_0000); set_evt(20, 1); idle(1);
    wr(8'h08, 20); idle(1); rd_chk(8'h20); rd_chk(8'h48);
    set_evt(20, 0); wr(8'h08, 20); idle(1); rd_chk(8'h20);

    cur_tag = "R9";
    wr(8'h2C, 32'hFFFF_FFFF); idle(1);
    @(negedge clk_i);
    evt_i[33] = 1; wr_en_i = 1; wr_addr_i = 8'h08; wr_data_i = 33;
    idle(1); rd_chk(8'h24);

    cur_tag = "R10";
    wr(8'h00, 32'h0); idle(2); check("irq_o gated", irq_o, 64'h0);
    wr(8'h00, 32'h1); idle(2);

    cur_tag = "R11";
    rd_chk(8'h60); rd_chk(8'h28); rd_chk(8'h04); rd_chk(8'h00);

    cur_tag = "R10";
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      @(negedge clk_i);
      evt_i ^= {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      case ($urandom % 16)
        0: a = 8'h00;  1: a = 8'h04;  2: a = 8'h08;  3: a = 8'h0C;
        4: a = 8'h10;  5: a = 8'h28;  6: a = 8'h2C;  7: a = 8'h30;
        8: a = 8'h34;  9: a = 8'h38;  10: a = 8'h3C; 11: a = 8'h40;
        12: a = 8'h44; 13: a = 8'h48; 14: a = 8'h4C; default: a = 8'h60;
      endcase
      d = (a inside {8'h04, 8'h08, 8'h0C, 8'h10}) ? ($urandom % 80) : $urandom;
      if (a == 8'h00) d = ($urandom % 4 != 0);
      wr_en_i = ($urandom % 3 != 0); wr_addr_i = a; wr_data_i = d;
      rd_addr_i = {2'b0, 4'($urandom % 6), 2'b0} + 8'h40;
      #1 check("rand read", {32'h0, rd_data_o}, {32'h0, m_rd(rd_addr_i)});
    end
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule